// File: doc/BRIEF.md
# Machine Check and Checkstop Controller

This block decides what a simple processor core does when hardware reports a serious error. Four error sources are sampled on every clock edge: an external machine-check pin, a bus transfer-error acknowledge, a data parity error and an address parity error. The block also samples an external checkstop request. The block holds the machine-state register (MSR) of the core. When the machine-check-enable bit of that register is set, an error becomes a recoverable exception. The block saves the next-instruction address and a status word that records the cause and part of the old MSR. It then rewrites the MSR and pulses an exception strobe with the machine-check vector.

When the enable bit is clear, or when the external checkstop request is present, the core instead enters checkstop. This state is terminal. The checkstop output stays high until reset, all saved state stops changing, and a freeze output follows within a bounded number of edges so that the rest of the core can halt for later inspection. Handler software is modelled by a write port that reloads the MSR, which is how the enable bit is set again after an exception.

Bit positions use 32-bit words written with LSB index 0. The big-endian bit k of the architecture is LSB index 31-k. The deassertion of `rst_n` must be synchronous to `clk`.

Top module: `mchk_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ckstp_o`, `freeze_o` and `exc_take_o` are 0, `exc_vec_o` is 0, `save_pc_o` and `save_sts_o` are 0, and `msr_o` equals RST_MSR (default 0x0000_1000, which has only the enable bit at LSB index 12 set).
- R2: An edge that samples any error source high while MSR bit 12 is 1, with no checkstop request and outside checkstop, raises `exc_take_o` for exactly the next cycle. `exc_vec_o` shows 0x00200 in that cycle and 0 in all other cycles.
- R3: On a taken exception, `save_pc_o` is loaded with `nia_i` as sampled on that edge.
- R4: On a taken exception, `save_sts_o[31:20]` becomes 0 and `save_sts_o[15:0]` becomes the MSR bits [15:0] held before that edge.
- R5: The cause bits are `save_sts_o[19]` for the machine-check pin, [18] for the transfer-error acknowledge, [17] for the data parity error and [16] for the address parity error. Each source asserted on the edge sets its own bit, and all other cause bits are 0.
- R6: On a taken exception, the new MSR has LSB indices 18, 17, 15, 14, 13, 12, 11, 10, 9, 8, 6, 5, 4 and 1 cleared. Index 0 is loaded from index 16, and every other bit keeps its value.
- R7: An error sampled while MSR bit 12 is 0 enters checkstop: `ckstp_o` is 1 after that edge, no strobe occurs, and the saved registers and MSR keep their values.
- R8: A sampled checkstop request enters checkstop whatever MSR bit 12 holds. If error sources are asserted on the same edge, the request wins: no strobe, and the saved registers are unchanged.
- R9: Checkstop is sticky until `rst_n` goes low. While in it, errors, requests and MSR writes have no effect on `msr_o`, `save_pc_o`, `save_sts_o` or `exc_take_o`.
- R10: `freeze_o` rises on the FRZ_LAT-th edge after the edge that raised `ckstp_o` (FRZ_LAT is 1 or 2, default 2) and stays high. It is never high without `ckstp_o`.
- R11: An edge that samples `msr_wr_en_i` high outside checkstop loads `msr_wr_data_i` into the MSR. If an exception is taken on that same edge, the exception image wins.
- R12: Because the enable bit is cleared on entry, a second transfer-error acknowledge that comes before software writes the bit back causes checkstop. After the bit is written back, a further error is again a taken exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, synchronous release |
| mcp_i | input | 1 | External machine-check pin |
| tea_i | input | 1 | Bus transfer-error acknowledge |
| dpe_i | input | 1 | Data parity error |
| ape_i | input | 1 | Address parity error |
| ckstp_req_i | input | 1 | External checkstop request |
| nia_i | input | 32 | Address of the next instruction to complete |
| msr_wr_en_i | input | 1 | Software MSR write strobe |
| msr_wr_data_i | input | 32 | Software MSR write value |
| msr_o | output | 32 | Current machine-state register |
| save_pc_o | output | 32 | Saved next-instruction address |
| save_sts_o | output | 32 | Saved status word |
| exc_take_o | output | 1 | One-cycle machine-check exception strobe |
| exc_vec_o | output | 20 | Vector offset, valid with the strobe |
| ckstp_o | output | 1 | Checkstop state |
| freeze_o | output | 1 | Pipeline freeze |

## Verification
Every result except freeze is registered once. The strobe, vector, saved registers, new MSR and `ckstp_o` are therefore due one edge after the edge that samples the stimulus. The bench drives inputs on falling edges and reads the outputs on the next falling edge. A second falling-edge read confirms that the strobe has dropped. `freeze_o` is read on each falling edge after checkstop is entered, and the expected value is 1 only once FRZ_LAT edges have passed. Saved state is recorded before a checkstop and compared again after later stimulus, which shows that the inputs had no effect.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // big-endian bit number -> LSB index
  function automatic int lsb_of(input int be_bit);
    return WORD_W - 1 - be_bit;
  endfunction

  localparam int MSR_ME   = lsb_of(19);
  localparam int MSR_ILE  = lsb_of(15);
  localparam int MSR_LE   = lsb_of(31);
  localparam int STS_KEEP_HI  = lsb_of(16);
  localparam int STS_CAUSE_HI = lsb_of(12);
  localparam int STS_CAUSE_LO = lsb_of(15);

  // MSR bits cleared when a machine check is taken
  function automatic word_t msr_clear_mask();
    word_t m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) begin
      case (b)
        13, 14, 16, 17, 18, 19, 20, 21, 22, 23, 25, 26, 27, 30: m[WORD_W-1-b] = 1'b1;
        default: ;
      endcase
    end
    return m;
  endfunction

  localparam word_t MSR_CLR = msr_clear_mask();

  // order matches the status word, MSB first
  typedef struct packed {
    logic mcp;
    logic tea;
    logic dpe;
    logic ape;
  } cause_t;

  localparam int CAUSE_W = $bits(cause_t);

endpackage

// File: rtl/mchk_cause.sv
module mchk_cause
  import mchk_pkg::*;
(
  input  logic   mcp_i,
  input  logic   tea_i,
  input  logic   dpe_i,
  input  logic   ape_i,
  output cause_t cause_o,
  output logic   any_o
);

  always_comb begin
    cause_o.mcp = mcp_i;
    cause_o.tea = tea_i;
    cause_o.dpe = dpe_i;
    cause_o.ape = ape_i;
    any_o       = mcp_i | tea_i | dpe_i | ape_i;
  end

endmodule

// File: rtl/mchk_image.sv
module mchk_image
  import mchk_pkg::*;
(
  input  word_t  msr_i,
  input  cause_t cause_i,
  output word_t  sts_o,
  output word_t  msr_o
);

  logic [CAUSE_W-1:0] cause_vec;
  assign cause_vec = cause_i;

  for (genvar i = 0; i < WORD_W; i++) begin : g_sts
    if (i <= STS_KEEP_HI) begin : g_keep
      assign sts_o[i] = msr_i[i];
    end else if (i <= STS_CAUSE_HI) begin : g_cause
      assign sts_o[i] = cause_vec[i-STS_CAUSE_LO];
    end else begin : g_zero
      assign sts_o[i] = 1'b0;
    end
  end

  always_comb begin
    msr_o         = msr_i & ~MSR_CLR;
    msr_o[MSR_LE] = msr_i[MSR_ILE];
  end

endmodule

// File: rtl/mchk_halt.sv
module mchk_halt #(
  parameter int FRZ_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  output logic ckstp_o,
  output logic freeze_o
);

  localparam int CNT_W = $clog2(FRZ_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRZ_LAT - 1);

  logic             ck_q, ck_d;
  logic             frz_q, frz_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    ck_d   = ck_q | enter_i;
    frz_d  = frz_q;
    cnt_d  = cnt_q;
    cnt_en = ck_q & ~frz_q;
    if (cnt_en) begin
      if (cnt_q == CNT_LAST) frz_d = 1'b1;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b0;
      frz_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ck_q <= ck_d;
      if (cnt_en) begin
        frz_q <= frz_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign ckstp_o  = ck_q;
  assign freeze_o = frz_q;

endmodule

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter int          FRZ_LAT  = 2,
  parameter int          VEC_W    = 20,
  parameter logic [VEC_W-1:0] MCHK_VEC = 20'h00200,
  parameter logic [31:0] RST_MSR  = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcp_i,
  input  logic             tea_i,
  input  logic             dpe_i,
  input  logic             ape_i,
  input  logic             ckstp_req_i,
  input  logic [31:0]      nia_i,
  input  logic             msr_wr_en_i,
  input  logic [31:0]      msr_wr_data_i,
  output logic [31:0]      msr_o,
  output logic [31:0]      save_pc_o,
  output logic [31:0]      save_sts_o,
  output logic             exc_take_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic             ckstp_o,
  output logic             freeze_o
);

  cause_t cause;
  logic   evt;
  word_t  img_sts, img_msr;
  word_t  msr_q, msr_d, pc_q, sts_q;
  logic   take_q, take_d;
  logic   msr_en, enter, ck;

  mchk_cause u_cause (
    .mcp_i   (mcp_i),
    .tea_i   (tea_i),
    .dpe_i   (dpe_i),
    .ape_i   (ape_i),
    .cause_o (cause),
    .any_o   (evt)
  );

  mchk_image u_image (
    .msr_i   (msr_q),
    .cause_i (cause),
    .sts_o   (img_sts),
    .msr_o   (img_msr)
  );

  mchk_halt #(.FRZ_LAT(FRZ_LAT)) u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter_i  (enter),
    .ckstp_o  (ck),
    .freeze_o (freeze_o)
  );

  // routing decision
  always_comb begin
    take_d = ~ck & ~ckstp_req_i & evt & msr_q[MSR_ME];
    enter  = ~ck & (ckstp_req_i | (evt & ~msr_q[MSR_ME]));
    msr_en = take_d | (msr_wr_en_i & ~ck);
    msr_d  = take_d ? img_msr : msr_wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msr_q <= RST_MSR;
    else if (msr_en) msr_q <= msr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sts_q <= '0;
    end else if (take_d) begin
      pc_q  <= nia_i;
      sts_q <= img_sts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take_q <= 1'b0;
    else        take_q <= take_d;
  end

  assign msr_o      = msr_q;
  assign save_pc_o  = pc_q;
  assign save_sts_o = sts_q;
  assign exc_take_o = take_q;
  assign exc_vec_o  = take_q ? MCHK_VEC : '0;
  assign ckstp_o    = ck;

endmodule

// File: rtl/mchk_ctrl_chk.sv
module mchk_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] msr_o,
  input logic [31:0] save_pc_o,
  input logic [31:0] save_sts_o,
  input logic        exc_take_o,
  input logic        ckstp_o,
  input logic        freeze_o
);

  p_take_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_o |=> !exc_take_o);

  p_take_me_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_o |-> !msr_o[12]);

  p_ck_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_o |=> ckstp_o);

  p_ck_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_o |-> !exc_take_o);

  p_ck_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ckstp_o) |-> ($stable(save_pc_o) && $stable(save_sts_o) && $stable(msr_o)));

  p_freeze_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ckstp_o && $past(ckstp_o, 2)) |-> freeze_o);

  p_freeze_needs_ck_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> ckstp_o);

endmodule

bind mchk_ctrl mchk_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msr_o      (msr_o),
  .save_pc_o  (save_pc_o),
  .save_sts_o (save_sts_o),
  .exc_take_o (exc_take_o),
  .ckstp_o    (ckstp_o),
  .freeze_o   (freeze_o)
);

// File: tb/mchk_ctrl_bench.sv
module mchk_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRZ_LAT    = 2;
  localparam int WDOG_MAX   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mcp_i = 0, tea_i = 0, dpe_i = 0, ape_i = 0, ckstp_req_i = 0;
  logic [31:0] nia_i = '0;
  logic        msr_wr_en_i = 0;
  logic [31:0] msr_wr_data_i = '0;
  logic [31:0] msr_o, save_pc_o, save_sts_o;
  logic        exc_take_o, ckstp_o, freeze_o;
  logic [19:0] exc_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mchk_ctrl #(.FRZ_LAT(FRZ_LAT)) u_mchk_ctrl (
    .clk(clk), .rst_n(rst_n), .mcp_i(mcp_i), .tea_i(tea_i), .dpe_i(dpe_i),
    .ape_i(ape_i), .ckstp_req_i(ckstp_req_i), .nia_i(nia_i),
    .msr_wr_en_i(msr_wr_en_i), .msr_wr_data_i(msr_wr_data_i), .msr_o(msr_o),
    .save_pc_o(save_pc_o), .save_sts_o(save_sts_o), .exc_take_o(exc_take_o),
    .exc_vec_o(exc_vec_o), .ckstp_o(ckstp_o), .freeze_o(freeze_o)
  );

  // stimulus table: {msr before, cause {mcp,tea,dpe,ape}, nia}
  localparam int NVEC = 6;
  localparam logic [67:0] TBL [NVEC] = '{
    {32'h0000_1000, 4'b1000, 32'h0000_0100},
    {32'hFFFF_FFFF, 4'b0100, 32'h1234_5678},
    {32'h0001_1001, 4'b0010, 32'hDEAD_BEE0},
    {32'h0000_9F3C, 4'b0001, 32'h0000_0FFC},
    {32'hA5A5_B5A5, 4'b1111, 32'h8000_0004},
    {32'h0001_1000, 4'b0110, 32'h7FFF_FFF8}
  };

  function automatic int le(input int be_bit);
    return 31 - be_bit;
  endfunction

  function automatic logic [31:0] exp_sts(input logic [31:0] m, input logic [3:0] c);
    logic [31:0] r;
    r = '0;
    for (int k = 16; k < 32; k++) r[le(k)] = m[le(k)];
    for (int k = 0; k < 4; k++) r[le(12 + k)] = c[3-k];
    return r;
  endfunction

  function automatic logic [31:0] exp_msr(input logic [31:0] m);
    logic [31:0] r;
    int clr [14] = '{13, 14, 16, 17, 18, 19, 20, 21, 22, 23, 25, 26, 27, 30};
    r = m;
    for (int k = 0; k < 14; k++) r[le(clr[k])] = 1'b0;
    r[le(31)] = m[le(15)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_err(input logic [3:0] c, input logic req);
    {mcp_i, tea_i, dpe_i, ape_i} = c;
    ckstp_req_i = req;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_err(4'b0, 1'b0);
    msr_wr_en_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_msr(input logic [31:0] v);
    msr_wr_en_i = 1'b1;
    msr_wr_data_i = v;
    @(negedge clk);
    msr_wr_en_i = 1'b0;
  endtask

  // one error pulse; returns at the negedge after the sampling edge
  task automatic pulse(input logic [3:0] c, input logic req, input logic [31:0] nia);
    set_err(c, req);
    nia_i = nia;
    @(negedge clk);
    set_err(4'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_MAX && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WDOG_MAX);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m, pc0, sts0, msr0;
    logic [3:0]  c;
    logic [31:0] nia;

    // R1: reset state, checked during and after reset
    #(CLK_PERIOD);
    chk("R1 ckstp", {31'b0, ckstp_o}, 32'd0);
    chk("R1 msr in reset", msr_o, 32'h0000_1000);
    do_reset();
    chk("R1 ckstp", {31'b0, ckstp_o}, 32'd0);
    chk("R1 freeze", {31'b0, freeze_o}, 32'd0);
    chk("R1 take", {31'b0, exc_take_o}, 32'd0);
    chk("R1 vec", {12'b0, exc_vec_o}, 32'd0);
    chk("R1 pc", save_pc_o, 32'd0);
    chk("R1 sts", save_sts_o, 32'd0);
    chk("R1 msr", msr_o, 32'h0000_1000);

    // table walk: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < NVEC; i++) begin
      {m, c, nia} = TBL[i];
      wr_msr(m);
      chk("R11 write", msr_o, m);
      pulse(c, 1'b0, nia);
      chk("R2 strobe", {31'b0, exc_take_o}, 32'd1);
      chk("R2 vector", {12'b0, exc_vec_o}, 32'h0000_0200);
      chk("R3 pc", save_pc_o, nia);
      chk("R4 R5 sts", save_sts_o, exp_sts(m, c));
      chk("R6 msr", msr_o, exp_msr(m));
      chk("R7 no ckstp", {31'b0, ckstp_o}, 32'd0);
      @(negedge clk);
      chk("R2 strobe drop", {31'b0, exc_take_o}, 32'd0);
      chk("R2 vector drop", {12'b0, exc_vec_o}, 32'd0);
    end

    // R11: write and exception on the same edge, exception wins
    wr_msr(32'h0001_9000);
    msr_wr_en_i = 1'b1;
    msr_wr_data_i = 32'hFFFF_FFFF;
    pulse(4'b0001, 1'b0, 32'h0000_4444);
    msr_wr_en_i = 1'b0;
    chk("R11 take wins", msr_o, exp_msr(32'h0001_9000));

    // R12: second transfer error without handler -> checkstop
    do_reset();
    pulse(4'b0100, 1'b0, 32'h0000_1111);
    chk("R12 first taken", {31'b0, exc_take_o}, 32'd1);
    pc0 = save_pc_o; sts0 = save_sts_o; msr0 = msr_o;
    pulse(4'b0100, 1'b0, 32'h0000_2222);
    chk("R12 second ckstp", {31'b0, ckstp_o}, 32'd1);
    chk("R12 no strobe", {31'b0, exc_take_o}, 32'd0);
    chk("R7 pc kept", save_pc_o, pc0);
    chk("R7 sts kept", save_sts_o, sts0);

    // R12: with handler restoring enable bit, errors keep being exceptions
    do_reset();
    pulse(4'b0100, 1'b0, 32'h0000_3333);
    chk("R12 taken", {31'b0, exc_take_o}, 32'd1);
    wr_msr(msr_o | 32'h0000_1000);
    pulse(4'b0100, 1'b0, 32'h0000_5555);
    chk("R12 taken again", {31'b0, exc_take_o}, 32'd1);
    chk("R12 pc", save_pc_o, 32'h0000_5555);
    chk("R12 no ckstp", {31'b0, ckstp_o}, 32'd0);

    // R7 R10 R9: checkstop from error with enable bit clear
    do_reset();
    pulse(4'b1000, 1'b0, 32'h0000_0AA0);
    wr_msr(32'h0000_0000);
    pc0 = save_pc_o; sts0 = save_sts_o; msr0 = msr_o;
    pulse(4'b0010, 1'b0, 32'h0000_0BB0);
    chk("R7 ckstp", {31'b0, ckstp_o}, 32'd1);
    chk("R7 no strobe", {31'b0, exc_take_o}, 32'd0);
    chk("R7 msr kept", msr_o, msr0);
    for (int e = 0; e <= FRZ_LAT + 1; e++) begin
      chk("R10 freeze timing", {31'b0, freeze_o}, (e >= FRZ_LAT) ? 32'd1 : 32'd0);
      if (e < FRZ_LAT + 1) @(negedge clk);
    end
    msr_wr_en_i = 1'b1;
    msr_wr_data_i = 32'hFFFF_FFFF;
    pulse(4'b1111, 1'b0, 32'hCAFE_0000);
    msr_wr_en_i = 1'b0;
    chk("R9 no strobe", {31'b0, exc_take_o}, 32'd0);
    pulse(4'b0000, 1'b1, 32'hCAFE_0004);
    chk("R9 msr frozen", msr_o, msr0);
    chk("R9 pc frozen", save_pc_o, pc0);
    chk("R9 sts frozen", save_sts_o, sts0);
    chk("R9 still ckstp", {31'b0, ckstp_o}, 32'd1);
    chk("R10 still freeze", {31'b0, freeze_o}, 32'd1);
    do_reset();
    chk("R9 reset leaves", {31'b0, ckstp_o}, 32'd0);
    chk("R9 reset freeze", {31'b0, freeze_o}, 32'd0);

    // R8: request overrides same-edge errors with enable bit set
    pc0 = save_pc_o; sts0 = save_sts_o;
    pulse(4'b1010, 1'b1, 32'h0000_7770);
    chk("R8 ckstp", {31'b0, ckstp_o}, 32'd1);
    chk("R8 no strobe", {31'b0, exc_take_o}, 32'd0);
    chk("R8 pc kept", save_pc_o, pc0);
    chk("R8 sts kept", save_sts_o, sts0);
    chk("R8 msr kept", msr_o, 32'h0000_1000);

    // R8: request alone with enable bit clear
    do_reset();
    wr_msr(32'h0000_0000);
    pulse(4'b0000, 1'b1, 32'h0);
    chk("R8 ckstp me0", {31'b0, ckstp_o}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule